// File: doc/BRIEF.md
# Shift Merge and Sign-Extend Unit

A 16-bit single-operation datapath unit for a small graphics-oriented processor. In each cycle it takes one source word, two merge operands, a carry-in flag and an operation code. It produces a result word and the sign, zero, carry and overflow flags for that operation. There are five operations: a one-bit arithmetic right shift, a halving shift that maps minus one to zero, a rotate right through carry, a byte-to-word sign extension, and a byte merge. The merge packs the upper bytes of two texture coordinate operands into one word.

The operation is captured on a clock edge while `valid_i` is high. The result and flags are registered and appear one cycle later, qualified by `valid_o`. When nothing is issued, or when the operation code is unused, the outputs keep their last values. The register file and instruction sequencing sit outside the block. The caller supplies the carry-in and keeps the flags it receives.

Top module: `smx_unit`

## Requirements
- R1: With op code 0 (arithmetic shift right), the result is the source shifted right by one with bit 15 replicated, and carry takes source bit 0.
- R2: With op code 1 (halving), the result is the same as for op code 0, except that source 0xFFFF gives 0x0000. Carry takes source bit 0.
- R3: With op code 2 (rotate right), result bit 15 is the carry-in and bits 14:0 are source bits 15:1. Carry takes source bit 0.
- R4: With op code 3 (sign extend), bits 15:8 of the result copy source bit 7 and bits 7:0 copy source bits 7:0. Carry passes the carry-in through unchanged.
- R5: With op code 4 (merge), result bits 15:8 are bits 15:8 of `mrg_hi_i` and result bits 7:0 are bits 15:8 of `mrg_lo_i`. The source and carry-in are ignored.
- R6: For merge, zero is set exactly when (result AND 0xF0F0) is 0, and carry is set exactly when (result AND 0xE0E0) is nonzero.
- R7: For merge, sign is result bit 15 OR result bit 7, and overflow is set exactly when (result AND 0xC0C0) is nonzero.
- R8: For op codes 0 to 3, sign is result bit 15, zero is set exactly when the result is 0x0000, and overflow is 0.
- R9: The result and flags of an operation issued with `valid_i` high appear after the next rising clock edge, with `valid_o` high for that one cycle. Issuing on consecutive cycles gives one result per cycle.
- R10: When `valid_i` is low, or when the op code is 5, 6 or 7, `valid_o` goes low and the result and flags hold their previous values.
- R11: After reset, `valid_o`, `result_o` and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Issue an operation this cycle |
| op_i | input | 3 | Operation code: 0 asr, 1 halve, 2 ror, 3 sext, 4 merge |
| src_i | input | 16 | Source word for shift, rotate and extend |
| mrg_hi_i | input | 16 | Merge operand supplying the upper result byte |
| mrg_lo_i | input | 16 | Merge operand supplying the lower result byte |
| carry_i | input | 1 | Carry-in flag |
| valid_o | output | 1 | Result and flags updated this cycle |
| result_o | output | 16 | Result word |
| sign_o | output | 1 | Sign flag |
| zero_o | output | 1 | Zero flag |
| carry_o | output | 1 | Carry flag |
| ovf_o | output | 1 | Overflow flag |

## Verification
Two things happen in the same cycle: the output register presents the previous operation's result, and it captures the next operation. Possible faults are a stale carry feeding a rotate, or flags that belong to the wrong operation. The bench provokes this by issuing every table vector on consecutive cycles, switching operation type each time, and checks each output word and flag set against a reference model one cycle after issue. In the merge vectors the plain and merge flag rules disagree on purpose: one case has a nonzero result but a zero flag that is set, and others have carry or overflow set from bits that are not the top bit.

// File: rtl/smx_pkg.sv
package smx_pkg;
  typedef enum logic [2:0] {
    OP_ASR   = 3'd0,
    OP_HALF  = 3'd1,
    OP_ROR   = 3'd2,
    OP_SEXT  = 3'd3,
    OP_MERGE = 3'd4
  } smx_op_e;

  typedef struct packed {
    logic s;
    logic z;
    logic c;
    logic v;
  } smx_flags_t;
endpackage

// File: rtl/smx_shift_core.sv
module smx_shift_core
  import smx_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  smx_op_e            op_i,
  input  logic [DATA_W-1:0]  src_i,
  input  logic               carry_i,
  output logic [DATA_W-1:0]  res_o,
  output smx_flags_t         flags_o
);
  localparam int unsigned MSB  = DATA_W - 1;
  localparam int unsigned HALF = DATA_W / 2;

  logic [DATA_W-1:0] asr_w;
  logic              all_ones;

  assign asr_w    = {src_i[MSB], src_i[MSB:1]};
  assign all_ones = &src_i;

  always_comb begin
    res_o   = asr_w;
    flags_o = '0;
    flags_o.c = src_i[0];
    unique case (op_i)
      OP_ASR:  res_o = asr_w;
      OP_HALF: res_o = all_ones ? '0 : asr_w;
      OP_ROR:  res_o = {carry_i, src_i[MSB:1]};
      OP_SEXT: begin
        res_o     = {{(DATA_W-HALF){src_i[HALF-1]}}, src_i[HALF-1:0]};
        flags_o.c = carry_i;
      end
      default: res_o = asr_w;
    endcase
    flags_o.s = res_o[MSB];
    flags_o.z = (res_o == '0);
    flags_o.v = 1'b0;
  end
endmodule

// File: rtl/smx_byte_merge.sv
module smx_byte_merge
  import smx_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] hi_i,
  input  logic [DATA_W-1:0] lo_i,
  output logic [DATA_W-1:0] res_o,
  output smx_flags_t        flags_o
);
  localparam int unsigned HALF  = DATA_W / 2;
  localparam int unsigned NLANE = 2;

  // per-lane masks: top 4 / top 3 / top 2 bits of each byte lane
  logic [DATA_W-1:0] mask_z, mask_c, mask_v;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign mask_z[g*HALF +: HALF] = {4'hF, {(HALF-4){1'b0}}};
    assign mask_c[g*HALF +: HALF] = {3'h7, {(HALF-3){1'b0}}};
    assign mask_v[g*HALF +: HALF] = {2'h3, {(HALF-2){1'b0}}};
  end

  assign res_o     = {hi_i[DATA_W-1:HALF], lo_i[DATA_W-1:HALF]};
  assign flags_o.z = ~|(res_o & mask_z);
  assign flags_o.c = |(res_o & mask_c);
  assign flags_o.v = |(res_o & mask_v);
  assign flags_o.s = res_o[DATA_W-1] | res_o[HALF-1];
endmodule

// File: rtl/smx_unit.sv
module smx_unit
  import smx_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] mrg_hi_i,
  input  logic [DATA_W-1:0] mrg_lo_i,
  input  logic              carry_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              sign_o,
  output logic              zero_o,
  output logic              carry_o,
  output logic              ovf_o
);
  localparam int unsigned HALF = DATA_W / 2;

  smx_op_e           op_w;
  logic              legal_w, take_w;
  logic [DATA_W-1:0] sh_res, mg_res, nx_res;
  smx_flags_t        sh_flg, mg_flg, nx_flg, flg_q;
  logic              merge_q;

  assign op_w    = smx_op_e'(op_i);
  assign legal_w = (op_i <= 3'd4);
  assign take_w  = valid_i && legal_w;

  smx_shift_core #(.DATA_W(DATA_W)) i_shift (
    .op_i    (op_w),
    .src_i   (src_i),
    .carry_i (carry_i),
    .res_o   (sh_res),
    .flags_o (sh_flg)
  );

  smx_byte_merge #(.DATA_W(DATA_W)) i_merge (
    .hi_i    (mrg_hi_i),
    .lo_i    (mrg_lo_i),
    .res_o   (mg_res),
    .flags_o (mg_flg)
  );

  assign nx_res = (op_w == OP_MERGE) ? mg_res : sh_res;
  assign nx_flg = (op_w == OP_MERGE) ? mg_flg : sh_flg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      flg_q    <= '0;
      merge_q  <= 1'b0;
    end else begin
      valid_o <= take_w;
      if (take_w) begin
        result_o <= nx_res;
        flg_q    <= nx_flg;
        merge_q  <= (op_w == OP_MERGE);
      end
    end
  end

  assign sign_o  = flg_q.s;
  assign zero_o  = flg_q.z;
  assign carry_o = flg_q.c;
  assign ovf_o   = flg_q.v;

  assert_valid_lat_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i <= 3'd4) |=> valid_o);
  assert_hold_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && $stable(result_o) && $stable(flg_q));
  assert_shift_carry_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i <= 3'd2) |=> carry_o == $past(src_i[0]));
  assert_sext_carry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == 3'd3) |=> carry_o == $past(carry_i));
  assert_merge_bytes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == 3'd4) |=>
      result_o == {$past(mrg_hi_i[DATA_W-1:HALF]), $past(mrg_lo_i[DATA_W-1:HALF])});
  assert_plain_flags_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !merge_q |-> !ovf_o && zero_o == (result_o == '0) && sign_o == result_o[DATA_W-1]);
  assert_half_minus_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == 3'd1) && (&src_i) |=> result_o == '0 && carry_o);
endmodule

// File: tb/test_smx_unit.sv
module test_smx_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [15:0] src_i = '0, mrg_hi_i = '0, mrg_lo_i = '0;
  logic        carry_i = 1'b0;
  logic        valid_o;
  logic [15:0] result_o;
  logic        sign_o, zero_o, carry_o, ovf_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;

  smx_unit i_smx_unit (
    .clk_i, .rst_ni, .valid_i, .op_i, .src_i, .mrg_hi_i, .mrg_lo_i, .carry_i,
    .valid_o, .result_o, .sign_o, .zero_o, .carry_o, .ovf_o
  );

  // op, src, hi, lo, cin, expected result
  typedef struct packed {
    logic [2:0]  op;
    logic [15:0] src;
    logic [15:0] hi;
    logic [15:0] lo;
    logic        cin;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VT [NV] = '{
    '{3'd0, 16'h0001, 16'h0, 16'h0, 1'b0, 16'h0000},
    '{3'd0, 16'hFFFF, 16'h0, 16'h0, 1'b0, 16'hFFFF},
    '{3'd0, 16'h8000, 16'h0, 16'h0, 1'b1, 16'hC000},
    '{3'd0, 16'h0000, 16'h0, 16'h0, 1'b1, 16'h0000},
    '{3'd1, 16'h0001, 16'h0, 16'h0, 1'b0, 16'h0000},
    '{3'd1, 16'hFFFF, 16'h0, 16'h0, 1'b0, 16'h0000},
    '{3'd1, 16'h8000, 16'h0, 16'h0, 1'b1, 16'hC000},
    '{3'd1, 16'h0000, 16'h0, 16'h0, 1'b0, 16'h0000},
    '{3'd1, 16'hFFFE, 16'h0, 16'h0, 1'b0, 16'hFFFF},
    '{3'd2, 16'h0001, 16'h0, 16'h0, 1'b1, 16'h8000},
    '{3'd2, 16'hFFFF, 16'h0, 16'h0, 1'b1, 16'hFFFF},
    '{3'd2, 16'h8000, 16'h0, 16'h0, 1'b0, 16'h4000},
    '{3'd2, 16'h0000, 16'h0, 16'h0, 1'b1, 16'h8000},
    '{3'd2, 16'hFFFF, 16'h0, 16'h0, 1'b0, 16'h7FFF},
    '{3'd3, 16'h0001, 16'h0, 16'h0, 1'b1, 16'h0001},
    '{3'd3, 16'hFFFF, 16'h0, 16'h0, 1'b0, 16'hFFFF},
    '{3'd3, 16'h8000, 16'h0, 16'h0, 1'b1, 16'h0000},
    '{3'd3, 16'h0000, 16'h0, 16'h0, 1'b0, 16'h0000},
    '{3'd3, 16'h1280, 16'h0, 16'h0, 1'b1, 16'hFF80},
    '{3'd4, 16'h0001, 16'h0001, 16'hFFFF, 1'b0, 16'h00FF},
    '{3'd4, 16'hFFFF, 16'h8000, 16'h0000, 1'b1, 16'h8000},
    '{3'd4, 16'h8000, 16'h0000, 16'h0000, 1'b1, 16'h0000},
    '{3'd4, 16'h0000, 16'h0F00, 16'h1F00, 1'b0, 16'h0F1F},
    '{3'd4, 16'h0000, 16'h2000, 16'h0000, 1'b0, 16'h2000},
    '{3'd4, 16'h0000, 16'h0000, 16'h4000, 1'b0, 16'h0040},
    '{3'd4, 16'h0000, 16'h0800, 16'h00FF, 1'b0, 16'h0800},
    '{3'd4, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b0, 16'hFFFF}
  };

  // reference flags {s,z,c,v} from the requirements
  function automatic logic [3:0] ref_flags(vec_t v);
    logic [15:0] r;
    r = v.exp;
    if (v.op == 3'd4)
      return {r[15] | r[7], (r & 16'hF0F0) == 0, (r & 16'hE0E0) != 0, (r & 16'hC0C0) != 0};
    return {r[15], r == 16'h0, (v.op == 3'd3) ? v.cin : v.src[0], 1'b0};
  endfunction

  function automatic string req_of(logic [2:0] op);
    case (op)
      3'd0: return "R1/R8";
      3'd1: return "R2/R8";
      3'd2: return "R3/R8";
      3'd3: return "R4/R8";
      default: return "R5/R6/R7";
    endcase
  endfunction

  task automatic check(string req, logic [20:0] act, logic [20:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act={v%b r%h s%b z%b c%b o%b} exp={v%b r%h s%b z%b c%b o%b}", req,
               act[20], act[19:4], act[3], act[2], act[1], act[0],
               exp[20], exp[19:4], exp[3], exp[2], exp[1], exp[0]);
    end
  endtask

  function automatic logic [20:0] outs();
    return {valid_o, result_o, sign_o, zero_o, carry_o, ovf_o};
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    logic [20:0] hold;
    repeat (2) @(negedge clk_i);
    check("R11", outs(), '0);            // reset state
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R11", outs(), '0);            // no issue yet
    // back-to-back walk of the table (R9)
    for (int i = 0; i < NV; i++) begin
      valid_i  = 1'b1;
      op_i     = VT[i].op;
      src_i    = VT[i].src;
      mrg_hi_i = VT[i].hi;
      mrg_lo_i = VT[i].lo;
      carry_i  = VT[i].cin;
      @(negedge clk_i);
      check(req_of(VT[i].op), outs(), {1'b1, VT[i].exp, ref_flags(VT[i])});
    end
    // idle: outputs hold, valid drops (R10)
    hold = outs();
    valid_i = 1'b0; op_i = 3'd0; src_i = 16'h1234; carry_i = 1'b1;
    @(negedge clk_i);
    check("R10", outs(), {1'b0, hold[19:0]});
    // unused op codes ignored (R10)
    for (int k = 5; k < 8; k++) begin
      valid_i = 1'b1; op_i = 3'(k); src_i = 16'h5A5A;
      @(negedge clk_i);
      check("R10", outs(), {1'b0, hold[19:0]});
    end
    // single issue after idle: one-cycle latency then valid drops (R9)
    valid_i = 1'b1; op_i = 3'd3; src_i = 16'h007F; carry_i = 1'b0;
    @(negedge clk_i);
    valid_i = 1'b0;
    check("R9", outs(), {1'b1, 16'h007F, 4'b0000});
    @(negedge clk_i);
    check("R9", outs(), {1'b0, 16'h007F, 4'b0000});
    // reset mid-run clears outputs (R11)
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R11", outs(), '0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule